// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Next-Line Prefetch

This block is a small read-only instruction store that sits between a fetch stage and one 128-bit memory port. The fetch stage presents a 32-bit byte address; the cache returns the addressed 32-bit instruction word together with a hit flag in the same cycle. The cache holds 64 lines of four words each. Every line keeps one validity bit and an 18-bit tag. The four most significant address bits take no part in the lookup, so addresses that differ only there alias to the same instruction.

On a miss the controller latches the missing line address. It then fetches the whole 16-byte line with a single granted request, and the data are written into the array on the cycle after the grant. The refill runs on its own once it has started, so the fetch stage may drop its request while it is interlocked. When the port has no demand work, the controller asks for the line that follows the most recent hit and parks it in a one-line side buffer. A later miss on that line is served from the buffer without touching memory. This shortens the miss penalty from three cycles to two.

Top module: `instr_cache`

## Requirements
- R1: After reset every line is invalid and no prefetch is pending: `hit` and `memReq` are low, and the first fetch of any address misses.
- R2: A lookup hits only when the line at index `fetchAddr[9:4]` is valid and its stored tag equals `fetchAddr[27:10]`. Bits `[31:28]` are ignored, so an address that differs only there hits the same line.
- R3: Word `k` of a line is `memRdata[32k+31:32k]` as returned by memory, and `fetchAddr[3:2]` selects which word drives `instr`.
- R4: A demand miss with no matching prefetched line raises `memReq` with `memLineAddr = fetchAddr[27:4]` in the cycle after the miss. Memory returns `memRdata` one cycle after a granted request, and the line is written on that cycle. With an immediate grant the same fetch hits in the third cycle after the miss is first seen (penalty of 3 cycles).
- R5: While a demand request is not granted, `memReq` stays high and `memLineAddr` stays unchanged. The penalty grows by one cycle for each withheld grant.
- R6: A refill holds the port for exactly one cycle: `memReq` is low in the cycle after a granted demand request.
- R7: A refill that has started completes even if `fetchValid` drops, and the line then hits without any further miss.
- R8: While the controller is idle and no demand miss is present, it requests line `L+1` (24-bit line address) after a hit on line `L`, unless that line is already cached or buffered. No request is raised in the cycle a demand miss is first seen.
- R9: A miss on the line held in the prefetch buffer raises no memory request and hits two cycles after it is first seen.
- R10: A miss on any other line discards the buffered line and takes the three-cycle memory path. A later miss on the discarded line also goes to memory.
- R11: A one-cycle pulse on `invalidateAll` clears every valid bit and the prefetch buffer, so a line that hit before misses afterwards with the full three-cycle penalty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| invalidateAll | input | 1 | Clears all lines and the prefetch buffer |
| fetchValid | input | 1 | Fetch address is valid this cycle |
| fetchAddr | input | 32 | Byte address of the instruction |
| instr | output | 32 | Selected instruction word |
| hit | output | 1 | Valid fetch found its line |
| memReq | output | 1 | Line request to the shared memory port |
| memLineAddr | output | 24 | Requested line address (byte address bits 27:4) |
| memGrant | input | 1 | Port grants the request this cycle |
| memRdata | input | 128 | Line data, one cycle after a grant |

## Verification
A fixed walk of ten fetch addresses is run against a memory model whose words encode their own line address and word number. Each result therefore shows whether the right line and the right word came back. The walk mixes repeat hits and aliases that differ only in the top nibble. It also includes conflicting tags on the same index, an access at the last index, and misses on the buffered next line. Measuring the penalty of each fetch tells the two-cycle buffer path apart from the three-cycle memory path. It also exposes a buffer that was not discarded. Directed sequences withhold the grant to show the held request and the pending prefetch address. Further sequences drop the fetch during a refill and pulse the invalidate input.

// File: rtl/icache_pkg.sv
package icache_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  parameter int ADDR_W         = 32;
  parameter int IGNORE_W       = 4;
  parameter int WORD_W         = 32;
  parameter int WORDS_PER_LINE = 4;
  parameter int NUM_LINES      = 64;

  localparam int BYTE_OFF_W = $clog2(WORD_W / 8);
  localparam int WSEL_W     = $clog2(WORDS_PER_LINE);
  localparam int IDX_W      = $clog2(NUM_LINES);
  localparam int TAG_W      = ADDR_W - IGNORE_W - IDX_W - WSEL_W - BYTE_OFF_W;
  localparam int LADDR_W    = TAG_W + IDX_W;
  localparam int LINE_W     = WORD_W * WORDS_PER_LINE;
  localparam int LADDR_LSB  = WSEL_W + BYTE_OFF_W;
  localparam int LADDR_MSB  = ADDR_W - IGNORE_W - 1;

  typedef struct packed {
    logic clearAll;
    logic latchMiss;
    logic recordHit;
    logic selPf;
    logic pfLaunch;
    logic fillFromMem;
    logic fillFromBuf;
    logic capturePf;
    logic dropBuf;
  } ctrlStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MISS_REQ,
    ST_MISS_FILL,
    ST_BUF_FILL,
    ST_PF_FILL
  } ctrlState_t;
endpackage

// File: rtl/icache_datapath.sv
module icache_datapath
  import icache_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [ADDR_W-1:0]    fetchAddr,
  input  logic [LINE_W-1:0]    memRdata,
  output logic [WORD_W-1:0]    instr,
  output logic                 lookupHit,
  output logic                 bufMatch,
  output logic                 pfNeeded,
  output logic [LADDR_W-1:0]   memLineAddr
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [LADDR_W-1:0] LINE_ONE = {{(LADDR_W-1){1'b0}}, 1'b1};

  // storage
  logic [LINE_W-1:0]    dataArr [NUM_LINES];
  logic [TAG_W-1:0]     tagArr  [NUM_LINES];
  logic [NUM_LINES-1:0] validBits;

  // fetch address split
  logic [LADDR_W-1:0] fetchLine;
  logic [IDX_W-1:0]   fetchIdx;
  logic [TAG_W-1:0]   fetchTag;
  logic [WSEL_W-1:0]  wordSel;
  logic               unusedAddrBits;

  assign fetchLine      = fetchAddr[LADDR_MSB:LADDR_LSB];
  assign fetchIdx       = fetchLine[IDX_W-1:0];
  assign fetchTag       = fetchLine[LADDR_W-1:IDX_W];
  assign wordSel        = fetchAddr[LADDR_LSB-1:BYTE_OFF_W];
  assign unusedAddrBits = ^{fetchAddr[ADDR_W-1:LADDR_MSB+1], fetchAddr[BYTE_OFF_W-1:0]};

  // lookup and word multiplexer
  logic [LINE_W-1:0] selLine;
  logic [WORD_W-1:0] lineWords [WORDS_PER_LINE];

  assign selLine   = dataArr[fetchIdx];
  assign lookupHit = validBits[fetchIdx] && (tagArr[fetchIdx] == fetchTag);

  for (genvar w = 0; w < WORDS_PER_LINE; w++) begin : g_words
    assign lineWords[w] = selLine[w*WORD_W +: WORD_W];
  end

  assign instr = lineWords[wordSel];

  // miss address, prefetch candidate, prefetch buffer
  logic [LADDR_W-1:0] missLine;
  logic [LADDR_W-1:0] pfCandLine;
  logic               pfCandValid;
  logic [LADDR_W-1:0] pfReqLine;
  logic [LADDR_W-1:0] pfBufLine;
  logic [LINE_W-1:0]  pfBufData;
  logic               pfBufValid;

  logic [IDX_W-1:0] missIdx;
  logic [TAG_W-1:0] missTag;
  logic [IDX_W-1:0] candIdx;
  logic [TAG_W-1:0] candTag;
  logic             candCached;
  logic             candBuffered;

  assign missIdx      = missLine[IDX_W-1:0];
  assign missTag      = missLine[LADDR_W-1:IDX_W];
  assign candIdx      = pfCandLine[IDX_W-1:0];
  assign candTag      = pfCandLine[LADDR_W-1:IDX_W];
  assign candCached   = validBits[candIdx] && (tagArr[candIdx] == candTag);
  assign candBuffered = pfBufValid && (pfBufLine == pfCandLine);
  assign pfNeeded     = pfCandValid && !candCached && !candBuffered;
  assign bufMatch     = pfBufValid && (pfBufLine == fetchLine);
  assign memLineAddr  = strobes.selPf ? pfCandLine : missLine;

  always_ff @(posedge clk) begin
    if (strobes.fillFromMem) begin
      dataArr[missIdx] <= memRdata;
      tagArr[missIdx]  <= missTag;
    end else if (strobes.fillFromBuf) begin
      dataArr[missIdx] <= pfBufData;
      tagArr[missIdx]  <= missTag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearAll) begin
      validBits <= '0;
    end else if (strobes.fillFromMem || strobes.fillFromBuf) begin
      validBits[missIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.latchMiss) missLine <= fetchLine;
    if (strobes.pfLaunch)  pfReqLine <= pfCandLine;
    if (strobes.capturePf) begin
      pfBufData <= memRdata;
      pfBufLine <= pfReqLine;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearAll) begin
      pfCandValid <= 1'b0;
      pfCandLine  <= '0;
    end else if (strobes.recordHit) begin
      pfCandValid <= 1'b1;
      pfCandLine  <= fetchLine + LINE_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearAll) begin
      pfBufValid <= 1'b0;
    end else if (strobes.capturePf) begin
      pfBufValid <= 1'b1;
    end else if (strobes.fillFromBuf || strobes.dropBuf) begin
      pfBufValid <= 1'b0;
    end
  end

  // R11
  inval_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearAll |=> !lookupHit);

endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         invalidateAll,
  input  logic         fetchValid,
  input  logic         lookupHit,
  input  logic         bufMatch,
  input  logic         pfNeeded,
  input  logic         memGrant,
  output logic         memReq,
  output ctrlStrobes_t strobes
);
  timeunit 1ns;
  timeprecision 1ps;

  ctrlState_t state, nextState;

  always_comb begin
    strobes          = '0;
    strobes.clearAll = invalidateAll;
    memReq           = 1'b0;
    nextState        = state;
    case (state)
      ST_IDLE: begin
        if (fetchValid && !lookupHit) begin
          strobes.latchMiss = 1'b1;
          if (bufMatch) begin
            nextState = ST_BUF_FILL;
          end else begin
            strobes.dropBuf = 1'b1;
            nextState       = ST_MISS_REQ;
          end
        end else begin
          strobes.recordHit = fetchValid;
          if (pfNeeded) begin
            memReq        = 1'b1;
            strobes.selPf = 1'b1;
            if (memGrant) begin
              strobes.pfLaunch = 1'b1;
              nextState        = ST_PF_FILL;
            end
          end
        end
      end
      ST_MISS_REQ: begin
        memReq = 1'b1;
        if (memGrant) nextState = ST_MISS_FILL;
      end
      ST_MISS_FILL: begin
        strobes.fillFromMem = !invalidateAll;
        nextState           = ST_IDLE;
      end
      ST_BUF_FILL: begin
        strobes.fillFromBuf = !invalidateAll;
        nextState           = ST_IDLE;
      end
      ST_PF_FILL: begin
        strobes.capturePf = !invalidateAll;
        nextState         = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
    if (invalidateAll) nextState = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  // R4
  grant_fills_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MISS_REQ && memGrant && !invalidateAll)
      |=> (strobes.fillFromMem || invalidateAll));

  // R8
  miss_no_pf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && fetchValid && !lookupHit) |-> !memReq);

endmodule

// File: rtl/instr_cache.sv
module instr_cache
  import icache_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         invalidateAll,
  input  logic         fetchValid,
  input  logic [31:0]  fetchAddr,
  output logic [31:0]  instr,
  output logic         hit,
  output logic         memReq,
  output logic [23:0]  memLineAddr,
  input  logic         memGrant,
  input  logic [127:0] memRdata
);
  timeunit 1ns;
  timeprecision 1ps;

  ctrlStrobes_t strobes;
  logic         lookupHit;
  logic         bufMatch;
  logic         pfNeeded;

  icache_datapath i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .fetchAddr   (fetchAddr),
    .memRdata    (memRdata),
    .instr       (instr),
    .lookupHit   (lookupHit),
    .bufMatch    (bufMatch),
    .pfNeeded    (pfNeeded),
    .memLineAddr (memLineAddr)
  );

  icache_ctrl i_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .invalidateAll (invalidateAll),
    .fetchValid    (fetchValid),
    .lookupHit     (lookupHit),
    .bufMatch      (bufMatch),
    .pfNeeded      (pfNeeded),
    .memGrant      (memGrant),
    .memReq        (memReq),
    .strobes       (strobes)
  );

  assign hit = fetchValid && lookupHit;

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !strobes.selPf && !memGrant && !invalidateAll)
      |=> (memReq && $stable(memLineAddr)));

  // R6
  one_cycle_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !strobes.selPf && memGrant) |=> !memReq);

  // R9
  buf_no_mem_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.latchMiss && bufMatch && !invalidateAll) |=> !memReq);

endmodule

// File: tb/test_instr_cache.sv
module test_instr_cache;
  timeunit 1ns;
  timeprecision 1ps;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         invalidateAll = 1'b0;
  logic         fetchValid = 1'b0;
  logic [31:0]  fetchAddr = '0;
  logic [31:0]  instr;
  logic         hit;
  logic         memReq;
  logic [23:0]  memLineAddr;
  logic         memGrant;
  logic [127:0] memRdata = '0;
  logic         grantOn = 1'b1;

  int errors = 0;
  int checks = 0;

  assign memGrant = grantOn;

  always #4 clk = ~clk;

  instr_cache i_instr_cache (
    .clk(clk), .rstN(rstN), .invalidateAll(invalidateAll),
    .fetchValid(fetchValid), .fetchAddr(fetchAddr), .instr(instr), .hit(hit),
    .memReq(memReq), .memLineAddr(memLineAddr), .memGrant(memGrant),
    .memRdata(memRdata)
  );

  function automatic logic [31:0] wordOf(input logic [23:0] la, input logic [1:0] w);
    return {la, 4'hA, 2'b00, w};
  endfunction

  function automatic logic [31:0] expInstr(input logic [31:0] a);
    return wordOf(a[27:4], a[3:2]);
  endfunction

  // memory model: one-cycle read after a grant
  always @(posedge clk) begin
    if (memReq && memGrant)
      memRdata <= {wordOf(memLineAddr, 2'd3), wordOf(memLineAddr, 2'd2),
                   wordOf(memLineAddr, 2'd1), wordOf(memLineAddr, 2'd0)};
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic doFetch(input logic [31:0] a, output int pen, output bit sawReq);
    @(negedge clk);
    fetchValid = 1'b1;
    fetchAddr  = a;
    #1;
    pen = 0;
    sawReq = 1'b0;
    while (!hit && pen < 30) begin
      pen++;
      if (memReq) sawReq = 1'b1;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    fetchValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // address, expected miss penalty
  localparam logic [35:0] VEC [10] = '{
    {32'h0000_0100, 4'd3},  // R1 first fetch, R4
    {32'h0000_0108, 4'd0},  // R3 word 2
    {32'h0000_0114, 4'd2},  // R9 buffered next line
    {32'h1000_0104, 4'd0},  // R2 alias in top nibble
    {32'h0000_050C, 4'd3},  // R2 conflict tag, R10 drop
    {32'h0000_0100, 4'd3},  // R2 evicted line
    {32'h0000_0128, 4'd3},  // R10 dropped line goes to memory
    {32'h0000_03FC, 4'd3},  // last index, word 3
    {32'h0000_0400, 4'd2},  // R9 wrap into next tag
    {32'hF000_03F0, 4'd0}   // R2 alias, word 0
  };

  initial begin
    #(64'd1600000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%h expected=%h", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int pen;
    bit sawReq;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check(memReq == 1'b0, "R1", "memReq after reset", {31'd0, memReq}, 32'd0);
    check(hit == 1'b0, "R1", "hit after reset", {31'd0, hit}, 32'd0);

    // table walk
    for (int i = 0; i < 10; i++) begin
      doFetch(VEC[i][35:4], pen, sawReq);
      check(pen == int'(VEC[i][3:0]), "R2/R4/R9/R10", $sformatf("penalty entry %0d", i),
            pen, {28'd0, VEC[i][3:0]});
      check(instr == expInstr(VEC[i][35:4]), "R3", $sformatf("data entry %0d", i),
            instr, expInstr(VEC[i][35:4]));
      if (VEC[i][3:0] == 4'd2)
        check(!sawReq, "R9", $sformatf("no request entry %0d", i), {31'd0, sawReq}, 32'd0);
      if (VEC[i][3:0] == 4'd3)
        check(sawReq, "R4", $sformatf("request entry %0d", i), {31'd0, sawReq}, 32'd1);
      idle(4);
    end

    // R4 / R6 cycle profile on line 0x80
    @(negedge clk);
    fetchValid = 1'b1;
    fetchAddr  = 32'h0000_0800;
    #1;
    check(!hit && !memReq, "R4", "miss cycle 0", {30'd0, hit, memReq}, 32'd0);
    @(negedge clk); #1;
    check(memReq && memLineAddr == 24'h000080, "R4", "request cycle 1",
          {7'd0, memReq, memLineAddr}, {7'd0, 1'b1, 24'h000080});
    @(negedge clk); #1;
    check(!memReq && !hit, "R6", "port released cycle 2", {30'd0, hit, memReq}, 32'd0);
    @(negedge clk); #1;
    check(hit && instr == expInstr(32'h0000_0800), "R4", "hit cycle 3", instr,
          expInstr(32'h0000_0800));
    idle(4);

    // R8: prefetch request after a hit, grant withheld
    grantOn = 1'b0;
    doFetch(32'h0000_0128, pen, sawReq);
    check(pen == 0, "R8", "setup hit", pen, 32'd0);
    @(negedge clk);
    fetchValid = 1'b0;
    #1;
    check(memReq && memLineAddr == 24'h000013, "R8", "next-line request",
          {7'd0, memReq, memLineAddr}, {7'd0, 1'b1, 24'h000013});

    // R5: demand miss with grant withheld
    @(negedge clk);
    fetchValid = 1'b1;
    fetchAddr  = 32'h0000_0C00;
    #1;
    check(!hit && !memReq, "R8", "no request on miss cycle", {30'd0, hit, memReq}, 32'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      check(memReq && memLineAddr == 24'h0000C0 && !hit, "R5", $sformatf("held request %0d", k),
            {7'd0, memReq, memLineAddr}, {7'd0, 1'b1, 24'h0000C0});
    end
    @(negedge clk);
    grantOn = 1'b1;
    #1;
    check(memReq && !hit, "R5", "granted cycle", {30'd0, hit, memReq}, 32'd1);
    @(negedge clk); #1;
    check(!memReq && !hit, "R6", "released after grant", {30'd0, hit, memReq}, 32'd0);
    @(negedge clk); #1;
    check(hit && instr == expInstr(32'h0000_0C00), "R5", "hit after 6 cycles", instr,
          expInstr(32'h0000_0C00));
    idle(4);

    // R7: refill completes with fetch dropped
    @(negedge clk);
    fetchValid = 1'b1;
    fetchAddr  = 32'h0000_0208;
    #1;
    check(!hit, "R7", "initial miss", {31'd0, hit}, 32'd0);
    idle(5);
    doFetch(32'h0000_0208, pen, sawReq);
    check(pen == 0, "R7", "hit after background refill", pen, 32'd0);
    check(instr == expInstr(32'h0000_0208), "R7", "data", instr, expInstr(32'h0000_0208));
    idle(4);

    // R11: invalidate all
    @(negedge clk);
    invalidateAll = 1'b1;
    @(negedge clk);
    invalidateAll = 1'b0;
    doFetch(32'h0000_0208, pen, sawReq);
    check(pen == 3, "R11", "miss after invalidate", pen, 32'd3);
    check(instr == expInstr(32'h0000_0208), "R11", "data", instr, expInstr(32'h0000_0208));
    idle(4);
    doFetch(32'hF000_03F0, pen, sawReq);
    check(pen == 3, "R11", "other line invalid", pen, 32'd3);
    idle(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule